// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Separate Count Pulses

The block is a binary counter built from four-bit modulo-16 cells. The direction is not set by a mode pin. One input moves the count up and another moves it down, and each is sampled on the rising edge of the system clock. A master clear and an active-low parallel preset both act on the count at once, without waiting for a clock edge. Each cell drives an active-low carry while it sits at its top value and is being stepped up. It drives an active-low borrow while it sits at zero and is being stepped down.

The top module chains `STAGES` cells. Each cell counts on the carry or borrow of the cell below it, and every cell updates on the same clock edge. With the default two cells the block is a modulo-256 counter. Its outputs are the full count and the carry and borrow of the top cell, which are ready to feed a further chained block.

Top module: `updn_pulse_counter`

## Requirements
- R1: While `clr` is high, `q` is 0 and both `carry_n` and `borrow_n` are 1. A rising `clr` clears `q` at once, with no clock edge needed.
- R2: `clr` wins over `load_n`. With both active, `q` stays 0.
- R3: A falling `load_n` (with `clr` low) sets `q` to `din` at once, with no clock edge needed. While `load_n` stays low, each rising clock edge reloads `din` and both count inputs are ignored.
- R4: At a rising edge with `up_pulse`=1, `dn_pulse`=0, `load_n`=1 and `clr`=0, `q` becomes (`q`+1) mod 2^(4·STAGES).
- R5: At a rising edge with `dn_pulse`=1, `up_pulse`=0, `load_n`=1 and `clr`=0, `q` becomes (`q`−1) mod 2^(4·STAGES).
- R6: When both count inputs are 1, or both are 0, `q` does not change at the clock edge.
- R7: `carry_n` is 0 exactly when `q` holds all ones, `up_pulse`=1, `dn_pulse`=0, `load_n`=1 and `clr`=0. Otherwise it is 1.
- R8: `borrow_n` is 0 exactly when `q` is 0, `dn_pulse`=1, `up_pulse`=0, `load_n`=1 and `clr`=0. Otherwise it is 1.
- R9: Cells are chained through carry and borrow. A lower cell wrapping 15→0 on an up step raises the next cell by one on the same edge, and a lower cell wrapping 0→15 on a down step lowers it by one. The whole count therefore wraps 255→0 going up and 0→255 going down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; counting happens on its rising edge |
| clr | input | 1 | Master clear, active high, asynchronous |
| load_n | input | 1 | Parallel preset, active low, asynchronous |
| up_pulse | input | 1 | Count-up request, sampled at each rising edge |
| dn_pulse | input | 1 | Count-down request, sampled at each rising edge |
| din | input | 4·STAGES (8) | Preset value |
| q | output | 4·STAGES (8) | Current count |
| carry_n | output | 1 | Terminal count going up, active low |
| borrow_n | output | 1 | Terminal count going down, active low |

## Verification
The step, hold and terminal-count properties assume three things about the inputs:
- `clr` and `load_n` stay at one level across each clock edge.
- `load_n` never falls and rises again between two edges.
- The count inputs are steady around each edge.

The bench changes every input only at the falling clock edge. It holds preset and clear active across at least one rising edge. It tests the immediate effect of preset and clear between edges and then keeps them asserted through the next edge. The properties are disabled while clear or preset is active, so the immediate jumps fall outside their step windows.

// File: rtl/ud_cnt_pkg.sv
package ud_cnt_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_t;
endpackage

// File: rtl/ud_step_decode.sv
module ud_step_decode
  import ud_cnt_pkg::*;
(
  input  logic  up_i,
  input  logic  dn_i,
  input  logic  load_n,
  output step_t step
);
  // preset blocks counting; simultaneous or absent requests hold the count
  always_comb begin
    if (!load_n)            step = STEP_HOLD;
    else if (up_i && !dn_i) step = STEP_INC;
    else if (dn_i && !up_i) step = STEP_DEC;
    else                    step = STEP_HOLD;
  end
endmodule

// File: rtl/ud_cnt_cell.sv
module ud_cnt_cell
  import ud_cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_n,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry_n,
  output logic         borrow_n
);
  localparam logic [W-1:0] TOPV  = '1;
  localparam logic [W-1:0] ZEROV = '0;

  step_t step;

  ud_step_decode u_dec (
    .up_i  (up_i),
    .dn_i  (dn_i),
    .load_n(load_n),
    .step  (step)
  );

  always_ff @(posedge clk or posedge clr or negedge load_n) begin
    if (clr)          q <= ZEROV;
    else if (!load_n) q <= din;
    else begin
      case (step)
        STEP_INC: q <= q + 1'b1;
        STEP_DEC: q <= q - 1'b1;
        default:  q <= q;
      endcase
    end
  end

  assign carry_n  = ~((step == STEP_INC) && (q == TOPV)  && !clr);
  assign borrow_n = ~((step == STEP_DEC) && (q == ZEROV) && !clr);

  AST_INC_STEP: assert property (@(posedge clk) disable iff (clr || !load_n)
    (step == STEP_INC) |=> (q == W'($past(q) + 1'b1))); // R4
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (clr || !load_n)
    (step == STEP_DEC) |=> (q == W'($past(q) - 1'b1))); // R5
  AST_HOLD_STEP: assert property (@(posedge clk) disable iff (clr || !load_n)
    (step == STEP_HOLD) |=> $stable(q)); // R6
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (clr || !load_n)
    !carry_n |=> (q == ZEROV)); // R7
  AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (clr || !load_n)
    !borrow_n |=> (q == TOPV)); // R8
endmodule

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter #(
  parameter int CELL_W = 4,
  parameter int STAGES = 2
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       load_n,
  input  logic                       up_pulse,
  input  logic                       dn_pulse,
  input  logic [CELL_W*STAGES-1:0]   din,
  output logic [CELL_W*STAGES-1:0]   q,
  output logic                       carry_n,
  output logic                       borrow_n
);
  localparam int TW = CELL_W * STAGES;

  logic [STAGES:0] up_link;
  logic [STAGES:0] dn_link;

  assign up_link[0] = up_pulse;
  assign dn_link[0] = dn_pulse;

  for (genvar k = 0; k < STAGES; k++) begin : g_cell
    logic cn, bn;
    ud_cnt_cell #(.W(CELL_W)) u_cell (
      .clk     (clk),
      .clr     (clr),
      .load_n  (load_n),
      .up_i    (up_link[k]),
      .dn_i    (dn_link[k]),
      .din     (din[k*CELL_W +: CELL_W]),
      .q       (q[k*CELL_W +: CELL_W]),
      .carry_n (cn),
      .borrow_n(bn)
    );
    assign up_link[k+1] = ~cn;
    assign dn_link[k+1] = ~bn;
  end

  assign carry_n  = ~up_link[STAGES];
  assign borrow_n = ~dn_link[STAGES];

  AST_CLR_ZERO: assert property (@(posedge clk)
    clr |-> (q == '0 && carry_n && borrow_n)); // R1
  AST_CLR_OVER_LOAD: assert property (@(posedge clk)
    (clr && !load_n) |-> (q == '0)); // R2
  AST_CHAIN_UP_WRAP: assert property (@(posedge clk) disable iff (clr || !load_n)
    (q == {TW{1'b1}} && up_pulse && !dn_pulse) |=> (q == '0)); // R9
  AST_CHAIN_DN_WRAP: assert property (@(posedge clk) disable iff (clr || !load_n)
    (q == '0 && dn_pulse && !up_pulse) |=> (q == {TW{1'b1}})); // R9
endmodule

// File: tb/sim_updn_pulse_counter.sv
`timescale 1ns/1ps
module sim_updn_pulse_counter;
  logic       clk = 1'b0;
  logic       clr, load_n, up_pulse, dn_pulse;
  logic [7:0] din, q;
  logic       carry_n, borrow_n;
  int nchk = 0, nfail = 0;
  bit done = 0;
  int e;

  always #2 clk = ~clk;

  updn_pulse_counter u0 (
    .clk(clk), .clr(clr), .load_n(load_n), .up_pulse(up_pulse),
    .dn_pulse(dn_pulse), .din(din), .q(q), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // drive up/dn at a falling edge, check terminal counts, then step one clock
  task automatic step(bit u, bit d);
    up_pulse = u; dn_pulse = d;
    #1;
    chk("R7 carry_n", carry_n, (e == 255 && u && !d) ? 0 : 1);
    chk("R8 borrow_n", borrow_n, (e == 0 && d && !u) ? 0 : 1);
    @(negedge clk);
    if (u && !d) e = (e + 1) & 255;
    else if (d && !u) e = (e - 1) & 255;
    chk("R4 R5 R6 R9 count", q, e);
  endtask

  task automatic t_reset;
    clr = 1; load_n = 1; up_pulse = 1; dn_pulse = 0; din = 8'h3C;
    @(negedge clk); @(negedge clk);
    chk("R1 q in clear", q, 0);
    chk("R1 carry_n in clear", carry_n, 1);
    chk("R1 borrow_n in clear", borrow_n, 1);
    up_pulse = 0; clr = 0; e = 0;
    @(negedge clk);
  endtask

  task automatic t_up_sweep;
    for (int i = 0; i < 300; i++) step(1, 0);
  endtask

  task automatic t_down_sweep;
    for (int i = 0; i < 300; i++) step(0, 1);
  endtask

  task automatic t_pulsed;
    for (int i = 0; i < 40; i++) step(i % 3 == 0, 0);
    for (int i = 0; i < 40; i++) step(0, i % 2 == 0);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 5; i++) step(1, 1);
    for (int i = 0; i < 5; i++) step(0, 0);
  endtask

  task automatic t_load;
    din = 8'hA5; up_pulse = 1; dn_pulse = 0;
    load_n = 0; #1;
    chk("R3 immediate load", q, 8'hA5);
    @(negedge clk);
    chk("R3 counts ignored during load", q, 8'hA5);
    din = 8'hFF; @(negedge clk);
    chk("R3 reload each edge", q, 8'hFF);
    chk("R7 no carry during load", carry_n, 1);
    din = 8'h00; up_pulse = 0; dn_pulse = 1; #1;
    chk("R8 no borrow during load", borrow_n, 1);
    @(negedge clk);
    chk("R3 reload zero", q, 0);
    load_n = 1; e = 0;
    step(0, 1);  // 0 -> 255 with borrow
    step(1, 0);  // 255 -> 0 with carry
    din = 8'h0F; load_n = 0; up_pulse = 0; dn_pulse = 0;
    @(negedge clk); load_n = 1; e = 15;
    step(1, 0);
    chk("R9 low cell carry into upper", q, 8'h10);
    step(0, 1);
    chk("R9 low cell borrow from upper", q, 8'h0F);
  endtask

  task automatic t_clear_priority;
    din = 8'h77; load_n = 0; #1;
    chk("R3 load 0x77", q, 8'h77);
    clr = 1; #1;
    chk("R2 clear over load immediate", q, 0);
    @(negedge clk);
    chk("R2 clear over load at edge", q, 0);
    clr = 0; @(negedge clk);
    chk("R3 load after clear released", q, 8'h77);
    load_n = 1; e = 8'h77;
    step(1, 0);
    clr = 1; #1;
    chk("R1 asynchronous clear", q, 0);
    @(negedge clk); clr = 0; e = 0;
    step(0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    clr = 1; load_n = 1; up_pulse = 0; dn_pulse = 0; din = 0;
    @(negedge clk);
    t_reset;
    t_up_sweep;
    t_down_sweep;
    t_pulsed;
    t_hold;
    t_load;
    t_clear_priority;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule